// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block takes one inter-processor interrupt request at a time and works out which processor agents it reaches. The request names a destination byte, a physical or logical addressing choice, a two-bit shorthand, a three-bit delivery code, a vector, trigger and level bits, and the slot index of the sender. Each agent slot supplies, through flat configuration buses, its own ID, its logical destination byte and a four-bit format nibble that chooses flat or cluster logical matching for that slot alone.

The resolver builds a mask with one bit per agent slot in the cycle after the request is accepted. In the following cycle it drives per-slot strobes sorted by delivery kind. Fixed and lowest-priority deliveries share one strobe bus tagged with the vector and trigger bit. Lowest priority is reduced to the lowest-indexed selected slot. System-management, non-maskable and init requests each have their own strobe bus. A startup request latches its vector into every selected slot. An init request with level clear and trigger set only copies each selected slot's ID into that slot's arbitration-ID register. The request port is a valid/ready handshake that admits a new request only once the previous strobes have retired.

Top module: `ipi_dest_resolver`

## Requirements
- R1: With physical addressing (req_logical=0) and shorthand 0, destination 8'hFF selects every slot. Any other destination selects only the lowest-indexed slot whose ID equals it, and no slot if none does.
- R2: With logical addressing and shorthand 0, a slot whose format nibble is 4'hF is selected when the destination ANDed with its logical byte is nonzero.
- R3: With logical addressing and shorthand 0, a slot whose format nibble is 4'h0 is selected when the upper nibbles of destination and logical byte are equal and their lower nibbles share a set bit. Any other format value never matches.
- R4: Shorthand 1 selects only the sender slot, 2 selects all slots, and 3 selects all slots but the sender. For shorthands 1 to 3, destination and addressing mode have no effect.
- R5: Delivery code 0 (fixed) drives irq_stb equal to the mask, with irq_vector and irq_trig copied from the request.
- R6: Delivery code 1 (lowest priority) drives irq_stb with only the lowest-indexed set bit of the mask.
- R7: Codes 2 (system management), 4 (non-maskable) and 5 (init) drive smi_stb, nmi_stb and init_stb with the mask, and no other strobe. Codes 3 and 7 drive no strobe.
- R8: Code 5 with req_level=0 and req_trig=1 drives no strobe. It loads arb_id[i*8 +: 8] from the slot's cfg_id for every selected slot and leaves the other slots unchanged.
- R9: Code 6 (startup) drives sipi_stb with the mask. It loads sipi_vec[i*8 +: 8] with the vector for selected slots and leaves the other slots unchanged.
- R10: After reset req_ready is 1, all strobes are 0, and arb_id and sipi_vec are 0. A request is accepted at the clock edge where req_valid and req_ready are both 1. Strobes are high only during the cycle that follows the second edge after acceptance. req_ready stays 0 from acceptance until those strobes have cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_shorthand | input | 2 | 0 dest, 1 self, 2 all, 3 all but self |
| req_dmode | input | 3 | Delivery code |
| req_vector | input | VEC_W | Vector |
| req_trig | input | 1 | Trigger mode (1 = level) |
| req_level | input | 1 | Level bit, used by init deassert |
| req_sender | input | IDX_W | Sender slot index |
| cfg_id | input | N_AGENTS*8 | Per-slot ID |
| cfg_logdest | input | N_AGENTS*8 | Per-slot logical destination byte |
| cfg_format | input | N_AGENTS*4 | Per-slot format nibble |
| irq_stb | output | N_AGENTS | Fixed / lowest-priority strobes |
| irq_vector | output | VEC_W | Vector tag for irq_stb |
| irq_trig | output | 1 | Trigger tag for irq_stb |
| smi_stb | output | N_AGENTS | System-management strobes |
| nmi_stb | output | N_AGENTS | Non-maskable strobes |
| init_stb | output | N_AGENTS | Init strobes |
| sipi_stb | output | N_AGENTS | Startup strobes |
| sipi_vec | output | N_AGENTS*VEC_W | Latched startup vector per slot |
| arb_id | output | N_AGENTS*8 | Arbitration ID per slot |

## Verification
Two reductions can act on the same request in the same cycle: the shorthand's removal of the sender slot and the lowest-priority pick of a single target. The bench provokes this with a lowest-priority request using shorthand 3 from sender slot 0. The pick must then land on slot 1, never on slot 0. A second overlap is the duplicate-ID pick in physical mode. There the bench gives two slots the same ID and expects only the lower one, and a lowest-priority broadcast must collapse to slot 0.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;
  localparam int DEST_W = 8;
  localparam int FMT_W  = 4;
  localparam int HALF_W = DEST_W / 2;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'd0,
    DM_LOWEST  = 3'd1,
    DM_SMI     = 3'd2,
    DM_RSV3    = 3'd3,
    DM_NMI     = 3'd4,
    DM_INIT    = 3'd5,
    DM_STARTUP = 3'd6,
    DM_RSV7    = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } short_e;

  localparam logic [FMT_W-1:0] FMT_FLAT    = 4'hF;
  localparam logic [FMT_W-1:0] FMT_CLUSTER = 4'h0;

  function automatic logic flat_hit(input logic [DEST_W-1:0] d, input logic [DEST_W-1:0] ld);
    return |(d & ld);
  endfunction

  function automatic logic cluster_hit(input logic [DEST_W-1:0] d, input logic [DEST_W-1:0] ld);
    return (d[DEST_W-1:HALF_W] == ld[DEST_W-1:HALF_W]) && (|(d[HALF_W-1:0] & ld[HALF_W-1:0]));
  endfunction

  function automatic logic logical_hit(input logic [DEST_W-1:0] d, input logic [DEST_W-1:0] ld,
                                       input logic [FMT_W-1:0] fmt);
    if (fmt == FMT_FLAT)         return flat_hit(d, ld);
    else if (fmt == FMT_CLUSTER) return cluster_hit(d, ld);
    else                         return 1'b0;
  endfunction

  function automatic logic is_arb_load(input logic [2:0] dm, input logic lvl, input logic trg);
    return (dmode_e'(dm) == DM_INIT) && !lvl && trg;
  endfunction
endpackage

// File: rtl/ipi_target_match.sv
module ipi_target_match
  import ipi_dest_pkg::*;
(
  input  logic [DEST_W-1:0] dest,
  input  logic [DEST_W-1:0] my_id,
  input  logic [DEST_W-1:0] my_logdest,
  input  logic [FMT_W-1:0]  my_format,
  output logic              phys_hit,
  output logic              log_hit
);
  assign phys_hit = (dest == my_id);
  assign log_hit  = logical_hit(dest, my_logdest, my_format);
endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
  parameter int W = 8
)(
  input  logic [W-1:0] req,
  output logic [W-1:0] grant
);
  assign grant = req & (~req + W'(1));
endmodule

// File: rtl/ipi_strobe_fanout.sv
module ipi_strobe_fanout
  import ipi_dest_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int VEC_W    = 8
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic [N_AGENTS-1:0]       mask,
  input  logic [2:0]                dmode,
  input  logic [VEC_W-1:0]          vector,
  input  logic                      trig,
  input  logic                      level,
  input  logic [N_AGENTS*DEST_W-1:0] cfg_id,
  output logic                      strobe_v,
  output logic                      arb_load_evt,
  output logic [N_AGENTS-1:0]       irq_stb,
  output logic [VEC_W-1:0]          irq_vector,
  output logic                      irq_trig,
  output logic [N_AGENTS-1:0]       smi_stb,
  output logic [N_AGENTS-1:0]       nmi_stb,
  output logic [N_AGENTS-1:0]       init_stb,
  output logic [N_AGENTS-1:0]       sipi_stb,
  output logic [N_AGENTS*VEC_W-1:0] sipi_vec,
  output logic [N_AGENTS*DEST_W-1:0] arb_id
);
  logic [N_AGENTS-1:0] lowest_oh;
  logic                sipi_evt;
  dmode_e              dm;

  assign dm           = dmode_e'(dmode);
  assign arb_load_evt = fire && is_arb_load(dmode, level, trig);
  assign sipi_evt     = fire && (dm == DM_STARTUP);

  ipi_lowest_pick #(.W(N_AGENTS)) u_lowest (.req(mask), .grant(lowest_oh));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_v   <= 1'b0;
      irq_stb    <= '0;
      smi_stb    <= '0;
      nmi_stb    <= '0;
      init_stb   <= '0;
      sipi_stb   <= '0;
      irq_vector <= '0;
      irq_trig   <= 1'b0;
    end else begin
      strobe_v <= fire;
      irq_stb  <= '0;
      smi_stb  <= '0;
      nmi_stb  <= '0;
      init_stb <= '0;
      sipi_stb <= '0;
      if (fire) begin
        irq_vector <= vector;
        irq_trig   <= trig;
        case (dm)
          DM_FIXED:   irq_stb  <= mask;
          DM_LOWEST:  irq_stb  <= lowest_oh;
          DM_SMI:     smi_stb  <= mask;
          DM_NMI:     nmi_stb  <= mask;
          DM_INIT:    if (!arb_load_evt) init_stb <= mask;
          DM_STARTUP: sipi_stb <= mask;
          default:    ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        arb_id[g*DEST_W +: DEST_W] <= '0;
        sipi_vec[g*VEC_W +: VEC_W] <= '0;
      end else begin
        if (arb_load_evt && mask[g]) arb_id[g*DEST_W +: DEST_W] <= cfg_id[g*DEST_W +: DEST_W];
        if (sipi_evt && mask[g])     sipi_vec[g*VEC_W +: VEC_W] <= vector;
      end
    end
  end
endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_dest_pkg::*;
#(
  parameter int N_AGENTS = 8,
  parameter int VEC_W    = 8,
  localparam int IDX_W   = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [DEST_W-1:0]           req_dest,
  input  logic                        req_logical,
  input  logic [1:0]                  req_shorthand,
  input  logic [2:0]                  req_dmode,
  input  logic [VEC_W-1:0]            req_vector,
  input  logic                        req_trig,
  input  logic                        req_level,
  input  logic [IDX_W-1:0]            req_sender,
  input  logic [N_AGENTS*DEST_W-1:0]  cfg_id,
  input  logic [N_AGENTS*DEST_W-1:0]  cfg_logdest,
  input  logic [N_AGENTS*FMT_W-1:0]   cfg_format,
  output logic [N_AGENTS-1:0]         irq_stb,
  output logic [VEC_W-1:0]            irq_vector,
  output logic                        irq_trig,
  output logic [N_AGENTS-1:0]         smi_stb,
  output logic [N_AGENTS-1:0]         nmi_stb,
  output logic [N_AGENTS-1:0]         init_stb,
  output logic [N_AGENTS-1:0]         sipi_stb,
  output logic [N_AGENTS*VEC_W-1:0]   sipi_vec,
  output logic [N_AGENTS*DEST_W-1:0]  arb_id
);
  logic [N_AGENTS-1:0] phys_hits, log_hits, phys_first, phys_mask;
  logic [N_AGENTS-1:0] dest_mask, self_oh, mask_d, mask_q;
  logic                accept, stage_a_v, strobe_v, arb_load_evt;
  logic [2:0]          dmode_q;
  logic [VEC_W-1:0]    vector_q;
  logic                trig_q, level_q;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_match
    ipi_target_match u_match (
      .dest      (req_dest),
      .my_id     (cfg_id[g*DEST_W +: DEST_W]),
      .my_logdest(cfg_logdest[g*DEST_W +: DEST_W]),
      .my_format (cfg_format[g*FMT_W +: FMT_W]),
      .phys_hit  (phys_hits[g]),
      .log_hit   (log_hits[g])
    );
  end

  ipi_lowest_pick #(.W(N_AGENTS)) u_phys_first (.req(phys_hits), .grant(phys_first));

  assign phys_mask = (req_dest == '1) ? '1 : phys_first;
  assign dest_mask = req_logical ? log_hits : phys_mask;
  assign self_oh   = N_AGENTS'(1) << req_sender;

  always_comb begin
    case (short_e'(req_shorthand))
      SH_SELF:   mask_d = self_oh;
      SH_ALL:    mask_d = '1;
      SH_OTHERS: mask_d = ~self_oh;
      default:   mask_d = dest_mask;
    endcase
  end

  assign req_ready = !stage_a_v && !strobe_v;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_a_v <= 1'b0;
      mask_q    <= '0;
      dmode_q   <= '0;
      vector_q  <= '0;
      trig_q    <= 1'b0;
      level_q   <= 1'b0;
    end else begin
      stage_a_v <= accept;
      if (accept) begin
        mask_q   <= mask_d;
        dmode_q  <= req_dmode;
        vector_q <= req_vector;
        trig_q   <= req_trig;
        level_q  <= req_level;
      end
    end
  end

  ipi_strobe_fanout #(.N_AGENTS(N_AGENTS), .VEC_W(VEC_W)) u_fanout (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (stage_a_v),
    .mask        (mask_q),
    .dmode       (dmode_q),
    .vector      (vector_q),
    .trig        (trig_q),
    .level       (level_q),
    .cfg_id      (cfg_id),
    .strobe_v    (strobe_v),
    .arb_load_evt(arb_load_evt),
    .irq_stb     (irq_stb),
    .irq_vector  (irq_vector),
    .irq_trig    (irq_trig),
    .smi_stb     (smi_stb),
    .nmi_stb     (nmi_stb),
    .init_stb    (init_stb),
    .sipi_stb    (sipi_stb),
    .sipi_vec    (sipi_vec),
    .arb_id      (arb_id)
  );
endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
  parameter int N_AGENTS = 8,
  parameter int IDX_W    = 3
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [1:0]            req_shorthand,
  input logic [2:0]            req_dmode,
  input logic [IDX_W-1:0]      req_sender,
  input logic [N_AGENTS-1:0]   irq_stb,
  input logic [N_AGENTS-1:0]   smi_stb,
  input logic [N_AGENTS-1:0]   nmi_stb,
  input logic [N_AGENTS-1:0]   init_stb,
  input logic [N_AGENTS-1:0]   sipi_stb,
  input logic [N_AGENTS*8-1:0] arb_id,
  input logic                  arb_load_evt,
  input logic                  strobe_v
);
  logic              acc1, acc2;
  logic [1:0]        sh1, sh2;
  logic [2:0]        dm1, dm2;
  logic [IDX_W-1:0]  snd1, snd2;
  logic [N_AGENTS-1:0] any_stb, self2;

  assign any_stb = irq_stb | smi_stb | nmi_stb | init_stb | sipi_stb;
  assign self2   = N_AGENTS'(1) << snd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc1 <= 1'b0; acc2 <= 1'b0;
      sh1 <= '0; sh2 <= '0; dm1 <= '0; dm2 <= '0; snd1 <= '0; snd2 <= '0;
    end else begin
      acc1 <= req_valid && req_ready; acc2 <= acc1;
      sh1 <= req_shorthand; sh2 <= sh1;
      dm1 <= req_dmode; dm2 <= dm1;
      snd1 <= req_sender; snd2 <= snd1;
    end
  end

  assert_lowest_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc2 && dm2 == 3'd1) |-> $onehot0(irq_stb));

  assert_others_skip_sender_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc2 && sh2 == 2'd3) |-> ((any_stb & self2) == '0));

  assert_class_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|irq_stb, |smi_stb, |nmi_stb, |init_stb, |sipi_stb}));

  assert_dropped_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc2 && (dm2 == 3'd3 || dm2 == 3'd7)) |-> (any_stb == '0));

  assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_v || acc1) |-> !req_ready);

  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb != '0) |=> (any_stb == '0));

  assert_arb_only_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_id != $past(arb_id)) |-> $past(arb_load_evt));
endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_shorthand(req_shorthand), .req_dmode(req_dmode), .req_sender(req_sender),
  .irq_stb(irq_stb), .smi_stb(smi_stb), .nmi_stb(nmi_stb), .init_stb(init_stb),
  .sipi_stb(sipi_stb), .arb_id(arb_id), .arb_load_evt(arb_load_evt), .strobe_v(strobe_v)
);

// File: tb/ipi_dest_resolver_bench.sv
module ipi_dest_resolver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_dest = '0;
  logic req_logical = 1'b0;
  logic [1:0] req_shorthand = '0;
  logic [2:0] req_dmode = '0;
  logic [7:0] req_vector = '0;
  logic req_trig = 1'b0, req_level = 1'b0;
  logic [2:0] req_sender = '0;
  logic [N*8-1:0] cfg_id, cfg_logdest;
  logic [N*4-1:0] cfg_format;
  logic [N-1:0] irq_stb, smi_stb, nmi_stb, init_stb, sipi_stb;
  logic [7:0] irq_vector;
  logic irq_trig;
  logic [N*8-1:0] sipi_vec, arb_id;

  logic [7:0] b_id [N];
  logic [7:0] b_ld [N];
  logic [3:0] b_fmt [N];

  int n_checks = 0;
  int n_fail = 0;

  logic [N-1:0] c_irq, c_smi, c_nmi, c_init, c_sipi;
  logic [7:0] c_vec;
  logic c_trig;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_id[i*8 +: 8]      = b_id[i];
      cfg_logdest[i*8 +: 8] = b_ld[i];
      cfg_format[i*4 +: 4]  = b_fmt[i];
    end
  end

  ipi_dest_resolver #(.N_AGENTS(N), .VEC_W(8)) u_ipi_dest_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_logical(req_logical), .req_shorthand(req_shorthand),
    .req_dmode(req_dmode), .req_vector(req_vector), .req_trig(req_trig),
    .req_level(req_level), .req_sender(req_sender), .cfg_id(cfg_id),
    .cfg_logdest(cfg_logdest), .cfg_format(cfg_format), .irq_stb(irq_stb),
    .irq_vector(irq_vector), .irq_trig(irq_trig), .smi_stb(smi_stb),
    .nmi_stb(nmi_stb), .init_stb(init_stb), .sipi_stb(sipi_stb),
    .sipi_vec(sipi_vec), .arb_id(arb_id)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic default_cfg();
    for (int i = 0; i < N; i++) begin
      b_id[i] = 8'h20 + 8'(i);
      b_ld[i] = 8'(1 << i);
      b_fmt[i] = 4'hF;
    end
  endtask

  task automatic issue(input logic [7:0] dest, input logic logical, input logic [1:0] sh,
                       input logic [2:0] dm, input logic [7:0] vec, input logic trg,
                       input logic lvl, input logic [2:0] snd);
    @(negedge clk);
    chk("R10 ready before request", 64'(req_ready), 64'd1);
    req_dest = dest; req_logical = logical; req_shorthand = sh; req_dmode = dm;
    req_vector = vec; req_trig = trg; req_level = lvl; req_sender = snd;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk("R10 ready low after accept", 64'(req_ready), 64'd0);
    chk("R10 no strobe in mask cycle", 64'(irq_stb | smi_stb | nmi_stb | init_stb | sipi_stb), 64'd0);
    @(negedge clk);
    c_irq = irq_stb; c_smi = smi_stb; c_nmi = nmi_stb; c_init = init_stb; c_sipi = sipi_stb;
    c_vec = irq_vector; c_trig = irq_trig;
    chk("R10 ready low during strobes", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R10 ready back", 64'(req_ready), 64'd1);
    chk("R10 strobes retired", 64'(irq_stb | smi_stb | nmi_stb | init_stb | sipi_stb), 64'd0);
  endtask

  task automatic chk_only_irq(input string tag, input logic [N-1:0] exp);
    chk(tag, 64'(c_irq), 64'(exp));
    chk({tag, " other lines"}, 64'(c_smi | c_nmi | c_init | c_sipi), 64'd0);
  endtask

  task automatic t_reset();
    chk("R10 reset ready", 64'(req_ready), 64'd1);
    chk("R10 reset strobes", 64'(irq_stb | smi_stb | nmi_stb | init_stb | sipi_stb), 64'd0);
    chk("R10 reset arb_id", arb_id, 64'd0);
    chk("R10 reset sipi_vec", sipi_vec, 64'd0);
  endtask

  task automatic t_physical();
    default_cfg();
    issue(8'hFF, 1'b0, 2'd0, 3'd0, 8'h41, 1'b1, 1'b0, 3'd0);
    chk_only_irq("R1 broadcast", 8'hFF);
    chk("R5 vector tag", 64'(c_vec), 64'h41);
    chk("R5 trigger tag", 64'(c_trig), 64'd1);
    issue(8'h23, 1'b0, 2'd0, 3'd0, 8'h42, 1'b0, 1'b0, 3'd0);
    chk_only_irq("R1 single id", 8'h08);
    chk("R5 trigger edge", 64'(c_trig), 64'd0);
    b_id[2] = 8'h77; b_id[6] = 8'h77;
    issue(8'h77, 1'b0, 2'd0, 3'd0, 8'h43, 1'b0, 1'b0, 3'd0);
    chk_only_irq("R1 duplicate id lowest", 8'h04);
    issue(8'h99, 1'b0, 2'd0, 3'd0, 8'h44, 1'b0, 1'b0, 3'd0);
    chk_only_irq("R1 no match", 8'h00);
  endtask

  task automatic t_flat();
    default_cfg();
    issue(8'h0A, 1'b1, 2'd0, 3'd0, 8'h50, 1'b0, 1'b0, 3'd0);
    chk_only_irq("R2 flat match", 8'h0A);
    issue(8'h00, 1'b1, 2'd0, 3'd0, 8'h51, 1'b0, 1'b0, 3'd0);
    chk_only_irq("R2 flat zero dest", 8'h00);
  endtask

  task automatic t_cluster();
    default_cfg();
    for (int i = 0; i < N; i++) b_fmt[i] = 4'h0;
    b_ld[0] = 8'h11; b_ld[1] = 8'h12; b_ld[2] = 8'h21; b_ld[3] = 8'h13;
    b_ld[4] = 8'h14; b_ld[5] = 8'h31; b_ld[6] = 8'h11; b_ld[7] = 8'h18;
    b_fmt[6] = 4'h5;
    issue(8'h13, 1'b1, 2'd0, 3'd0, 8'h60, 1'b0, 1'b0, 3'd0);
    chk_only_irq("R3 cluster match", 8'h0B);
    b_fmt[0] = 4'hF;
    issue(8'h21, 1'b1, 2'd0, 3'd0, 8'h61, 1'b0, 1'b0, 3'd0);
    chk_only_irq("R3 mixed flat and cluster", 8'h05);
  endtask

  task automatic t_shorthand();
    default_cfg();
    issue(8'h20, 1'b0, 2'd1, 3'd0, 8'h70, 1'b0, 1'b0, 3'd5);
    chk_only_irq("R4 self", 8'h20);
    issue(8'h20, 1'b1, 2'd2, 3'd0, 8'h71, 1'b0, 1'b0, 3'd5);
    chk_only_irq("R4 all", 8'hFF);
    issue(8'h20, 1'b0, 2'd3, 3'd0, 8'h72, 1'b0, 1'b0, 3'd5);
    chk_only_irq("R4 others", 8'hDF);
  endtask

  task automatic t_lowest();
    default_cfg();
    issue(8'h0C, 1'b1, 2'd0, 3'd1, 8'h80, 1'b0, 1'b0, 3'd0);
    chk_only_irq("R6 lowest of flat set", 8'h04);
    issue(8'hFF, 1'b0, 2'd0, 3'd1, 8'h81, 1'b0, 1'b0, 3'd0);
    chk_only_irq("R6 lowest of broadcast", 8'h01);
    issue(8'h00, 1'b0, 2'd3, 3'd1, 8'h82, 1'b1, 1'b0, 3'd0);
    chk_only_irq("R6 lowest with sender excluded", 8'h02);
    chk("R6 vector tag", 64'(c_vec), 64'h82);
  endtask

  task automatic t_lines();
    default_cfg();
    issue(8'h81, 1'b1, 2'd0, 3'd2, 8'h00, 1'b0, 1'b0, 3'd0);
    chk("R7 smi", 64'(c_smi), 64'h81);
    chk("R7 smi alone", 64'(c_irq | c_nmi | c_init | c_sipi), 64'd0);
    issue(8'h06, 1'b1, 2'd0, 3'd4, 8'h00, 1'b0, 1'b0, 3'd0);
    chk("R7 nmi", 64'(c_nmi), 64'h06);
    chk("R7 nmi alone", 64'(c_irq | c_smi | c_init | c_sipi), 64'd0);
    issue(8'h30, 1'b1, 2'd0, 3'd5, 8'h00, 1'b0, 1'b1, 3'd0);
    chk("R7 init", 64'(c_init), 64'h30);
    chk("R7 init alone", 64'(c_irq | c_smi | c_nmi | c_sipi), 64'd0);
    issue(8'hFF, 1'b0, 2'd0, 3'd3, 8'h90, 1'b0, 1'b0, 3'd0);
    chk("R7 code 3 dropped", 64'(c_irq | c_smi | c_nmi | c_init | c_sipi), 64'd0);
    issue(8'hFF, 1'b0, 2'd0, 3'd7, 8'h91, 1'b0, 1'b0, 3'd0);
    chk("R7 code 7 dropped", 64'(c_irq | c_smi | c_nmi | c_init | c_sipi), 64'd0);
    chk("R7 dropped leaves arb_id", arb_id, 64'd0);
  endtask

  task automatic t_arb_load();
    default_cfg();
    for (int i = 0; i < N; i++) b_id[i] = 8'h40 + 8'(i);
    issue(8'h05, 1'b1, 2'd0, 3'd5, 8'h00, 1'b1, 1'b0, 3'd0);
    chk("R8 no strobe", 64'(c_irq | c_smi | c_nmi | c_init | c_sipi), 64'd0);
    chk("R8 arb_id loaded", arb_id, 64'h0000_0000_0042_0040);
    b_id[2] = 8'h5A; b_id[1] = 8'h66;
    issue(8'h02, 1'b1, 2'd0, 3'd5, 8'h00, 1'b1, 1'b0, 3'd0);
    chk("R8 arb_id partial reload", arb_id, 64'h0000_0000_0042_6640);
  endtask

  task automatic t_startup();
    default_cfg();
    issue(8'h03, 1'b1, 2'd0, 3'd6, 8'h9A, 1'b0, 1'b0, 3'd0);
    chk("R9 sipi strobe", 64'(c_sipi), 64'h03);
    chk("R9 sipi alone", 64'(c_irq | c_smi | c_nmi | c_init), 64'd0);
    chk("R9 sipi vectors", sipi_vec, 64'h0000_0000_0000_9A9A);
    issue(8'h02, 1'b1, 2'd0, 3'd6, 8'h55, 1'b0, 1'b0, 3'd0);
    chk("R9 sipi vector update", sipi_vec, 64'h0000_0000_0000_559A);
  endtask

  initial begin
    default_cfg();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_physical();
    t_flat();
    t_cluster();
    t_shorthand();
    t_lowest();
    t_lines();
    t_arb_load();
    t_startup();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule